// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block is a register-driven master for the two-wire PHY management bus: a clock line (MDC) and a bidirectional data line (MDIO). Software sets a clock divisor and turns the interface on in a configuration word. It leaves the data to send in a write-data word. It then writes one packed control word that holds the PHY address, the register address, the operation and an initiate bit. The block sends a complete Clause 22 frame: 32 preamble ones, the start pattern, the opcode, both addresses, the turnaround and 16 data bits, most significant bit first.

On a read, the block releases the data line at the turnaround. It shifts in the 16 bits that the PHY returns and places them in a read-data word. The ready bit in the control word reads 0 for the whole frame and returns to 1 when the frame is over. Software polls that bit before a transaction and again after it.

The host side is a 32-bit request port with a two-bit word address. It takes a request every cycle and returns read data one cycle later.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset the configuration word (word address 0) reads 0x0000001D: divisor 29 in bits 5:0 and the enable bit (bit 6) clear. The control word (word 1) reads 0x00000080: only the ready bit is set. The write-data word (word 2) and the read-data word (word 3) read 0. MDC is low and the output enable is low.
- R2: The control word holds the PHY address in bits 28:24, the register address in bits 20:16, the read-select bit in bit 15 and the write-select bit in bit 14. These fields read back as written. Bit 11, the initiate bit, always reads 0. The write-data and read-data words use bits 15:0.
- R3: During a frame, MDC has a period of 2×(divisor+1) system clocks. MDC stays low while the block is idle. MDIO changes only after a falling MDC edge, and the PHY samples it on the rising edge.
- R4: A frame carries exactly 64 rising MDC edges. The line value at those edges is 32 ones, then 01, the opcode, the 5-bit PHY address, the 5-bit register address, the turnaround and 16 data bits, MSB first. The opcode is 10 for a read and 01 for a write.
- R5: On a read, the output enable is high up to the end of the register address. It drops for the first turnaround bit and stays low to the end of the frame. The 16 bits sampled from MDIO in appear in the read-data word once ready returns to 1.
- R6: On a write, the block drives 10 during the turnaround and keeps the output enable high through the data bits. The read-data word does not change.
- R7: The ready bit reads 0 right after a transaction starts and reads 1 again after the frame ends.
- R8: A control write with the initiate bit set while the enable bit is 0 starts nothing. Ready stays 1 and MDC does not toggle.
- R9: While a frame is in progress, writes to the configuration word and to the control word are ignored, including the initiate bit. The frame in progress finishes with its original fields.
- R10: If bit 15 of the control word is set, the operation is a read, even when bit 14 is also set. Otherwise the operation is a write.
- R11: The request port is always ready. A read request gives rsp_valid high, with the addressed word on rsp_rdata, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: 0 config, 1 control, 2 write data, 3 read data |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value sampled from the pad |

## Verification
A wrong bit counter or a wrong shift register shows up as a frame with the wrong length or misplaced fields. This is visible at the 64 recorded MDC rising edges of the same transaction. A divider fault changes the spacing between the first two rising edges. An output enable that drops at the wrong time shows at the turnaround of the first read. A busy flag that stays set, or one that starts without cause, shows in the ready bit at the next poll. A busy flag that stays set also leaves MDC running while the block is idle.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int FLD_BITS   = 5;
  localparam int CNT_W      = 7;
  localparam logic [CNT_W-1:0] TA_IDX   = 7'd46;
  localparam logic [CNT_W-1:0] DATA_IDX = 7'd48;
  localparam logic [CNT_W-1:0] LAST_IDX = 7'd63;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mgmt_opc_e;

  // Whole serial frame, MSB leaves first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic is_rd, input logic [FLD_BITS-1:0] pa,
      input logic [FLD_BITS-1:0] ra, input logic [DATA_BITS-1:0] wd);
    mgmt_opc_e opc;
    logic [1:0] ta;
    logic [DATA_BITS-1:0] dat;
    opc = is_rd ? OPC_READ : OPC_WRITE;
    ta  = is_rd ? 2'b11 : 2'b10;
    dat = is_rd ? '1 : wd;
    return {32'hFFFF_FFFF, 2'b01, opc, pa, ra, ta, dat};
  endfunction

  function automatic logic [31:0] cfg_word(input logic en, input logic [5:0] div);
    logic [31:0] w;
    w = '0;
    w[6] = en;
    w[5:0] = div;
    return w;
  endfunction
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap   = run && (cnt == div);
  assign rise_p = wrap && !mdc;
  assign fall_p = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_edges_follow_mdc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> mdc);
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 is_rd,
  input  logic [FLD_BITS-1:0]  pa,
  input  logic [FLD_BITS-1:0]  ra,
  input  logic [DATA_BITS-1:0] wd,
  input  logic                 rise_p,
  input  logic                 fall_p,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done_p,
  output logic [DATA_BITS-1:0] rd_data
);
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bitcnt;
  logic [DATA_BITS-1:0]  rd_sh;
  logic                  last_seen;
  logic                  rd_op;

  assign mdio_o = shreg[FRAME_BITS-1];
  assign done_p = busy && fall_p && last_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bitcnt    <= '0;
      rd_sh     <= '0;
      last_seen <= 1'b0;
      rd_op     <= 1'b0;
      busy      <= 1'b0;
      mdio_oe   <= 1'b0;
      rd_data   <= '0;
    end else if (start && !busy) begin
      shreg     <= build_frame(is_rd, pa, ra, wd);
      bitcnt    <= '0;
      last_seen <= 1'b0;
      rd_op     <= is_rd;
      busy      <= 1'b1;
      mdio_oe   <= 1'b1;
    end else if (busy) begin
      if (rise_p) begin
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt >= DATA_IDX) rd_sh <= {rd_sh[DATA_BITS-2:0], mdio_i};
        if (bitcnt == LAST_IDX) last_seen <= 1'b1;
      end
      if (fall_p) begin
        if (last_seen) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (rd_op) rd_data <= rd_sh;
        end else begin
          shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
          if (rd_op && bitcnt == TA_IDX) mdio_oe <= 1'b0;
        end
      end
    end
  end

  p_oe_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  p_mdio_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_p));
  p_write_keeps_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_op) |-> mdio_oe);
  p_read_oe_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_op && bitcnt > DATA_IDX) |-> !mdio_oe);
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DIV_W     = 6,
  parameter int DIV_RESET = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_WD  = ADDR_W'(2);

  logic                 cfg_en;
  logic [DIV_W-1:0]     cfg_div;
  logic [FLD_BITS-1:0]  ctl_pa, ctl_ra;
  logic                 ctl_rd, ctl_wr;
  logic [DATA_BITS-1:0] wd_reg;
  logic [DATA_BITS-1:0] rd_data;
  logic                 busy, rise_p, fall_p, done_p;
  logic                 wr_cfg, wr_ctl, start_p;
  logic [31:0]          rd_mux;
  logic                 unused_wbits;

  assign req_ready    = 1'b1;
  assign wr_cfg       = req_valid && req_write && req_addr == A_CFG && !busy;
  assign wr_ctl       = req_valid && req_write && req_addr == A_CTL && !busy;
  assign start_p      = wr_ctl && req_wdata[11] && cfg_en;
  assign unused_wbits = ^{req_wdata[31:29], req_wdata[23:21], req_wdata[13:12],
                          req_wdata[10:7], done_p};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      cfg_div <= DIV_W'(DIV_RESET);
      ctl_pa  <= '0;
      ctl_ra  <= '0;
      ctl_rd  <= 1'b0;
      ctl_wr  <= 1'b0;
      wd_reg  <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_en  <= req_wdata[6];
        cfg_div <= req_wdata[DIV_W-1:0];
      end
      if (wr_ctl) begin
        ctl_pa <= req_wdata[28:24];
        ctl_ra <= req_wdata[20:16];
        ctl_rd <= req_wdata[15];
        ctl_wr <= req_wdata[14];
      end
      if (req_valid && req_write && req_addr == A_WD) wd_reg <= req_wdata[15:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      A_CFG: rd_mux = cfg_word(cfg_en, 6'(cfg_div));
      A_CTL: begin
        rd_mux[28:24] = ctl_pa;
        rd_mux[20:16] = ctl_ra;
        rd_mux[15]    = ctl_rd;
        rd_mux[14]    = ctl_wr;
        rd_mux[7]     = !busy;
      end
      A_WD:    rd_mux[15:0] = wd_reg;
      default: rd_mux[15:0] = rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  mgmt_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div),
    .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p)
  );

  mgmt_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_p), .is_rd(req_wdata[15]),
    .pa(req_wdata[28:24]), .ra(req_wdata[20:16]), .wd(wd_reg),
    .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_p(done_p),
    .rd_data(rd_data)
  );

  p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_start_when_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_en));
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_div) && $stable(ctl_pa) && $stable(ctl_ra)));
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_p));
endmodule

// File: tb/tb_mgmt_serial_master.sv
module tb_mgmt_serial_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mdc, mdio_o, mdio_oe;
  logic [31:0] rsp_rdata;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mgmt_serial_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY-side monitor and responder
  int          cyc = 0;
  int          rcnt = 0;
  int          t1 = 0, t2 = 0;
  logic [63:0] obs = '0;
  logic        oe45 = 0, oe46 = 0;
  logic [15:0] phy_val = '0;

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    obs <= {obs[62:0], (mdio_oe ? mdio_o : mdio_i)};
    if (rcnt == 1) t1 <= cyc;
    if (rcnt == 2) t2 <= cyc;
    if (rcnt == 45) oe45 <= mdio_oe;
    if (rcnt == 46) oe46 <= mdio_oe;
    rcnt <= rcnt + 1;
  end

  always @(negedge mdc) begin
    if (rcnt == 47) mdio_i <= 1'b0;
    else if (rcnt >= 48 && rcnt <= 63) mdio_i <= phy_val[63 - rcnt];
    else mdio_i <= 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R11 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    d = rsp_rdata;
  endtask

  task automatic wait_ready(output int polls);
    logic [31:0] v;
    polls = 0;
    do begin
      rd(2'd1, v);
      polls++;
    end while (!v[7] && polls < 3000);
  endtask

  function automatic logic [31:0] ctl_word(input logic rdb, input logic wrb,
      input logic [4:0] pa, input logic [4:0] ra, input logic ini, input logic rdy);
    return {3'b000, pa, 3'b000, ra, rdb, wrb, 2'b00, ini, 3'b000, rdy, 7'd0};
  endfunction

  // {div[5:0], rd, wr, pa[4:0], ra[4:0], data[15:0]}
  localparam logic [33:0] VEC [5] = '{
    {6'd1, 1'b0, 1'b1, 5'h01, 5'h00, 16'h1234},
    {6'd2, 1'b1, 1'b0, 5'h1F, 5'h01, 16'hA5C3},
    {6'd0, 1'b0, 1'b1, 5'h10, 5'h1F, 16'hFFFF},
    {6'd3, 1'b1, 1'b1, 5'h0A, 5'h15, 16'h8001},
    {6'd1, 1'b1, 1'b0, 5'h00, 5'h00, 16'h7FFE}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [15:0] exp_rd;
    int polls;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 mdc", {63'd0, mdc}, 64'd0);
    check("R1 oe", {63'd0, mdio_oe}, 64'd0);
    check("R11 req_ready", {63'd0, req_ready}, 64'd1);
    rd(2'd0, v); check("R1 cfg", {32'd0, v}, 64'h1D);
    rd(2'd1, v); check("R1 ctl", {32'd0, v}, 64'h80);
    rd(2'd2, v); check("R1 wdata", {32'd0, v}, 64'd0);
    rd(2'd3, v); check("R1 rdata", {32'd0, v}, 64'd0);

    // R8 initiate while disabled
    rcnt = 0;
    wr(2'd1, ctl_word(1'b0, 1'b1, 5'h03, 5'h04, 1'b1, 1'b0));
    rd(2'd1, v); check("R8 ready stays", {63'd0, v[7]}, 64'd1);
    repeat (40) @(negedge clk);
    check("R8 no mdc edge", 64'(rcnt), 64'd0);
    check("R8 oe low", {63'd0, mdio_oe}, 64'd0);

    exp_rd = '0;
    for (int i = 0; i < 5; i++) begin
      logic [5:0] dv; logic rb, wb; logic [4:0] pa, ra; logic [15:0] dat;
      logic [63:0] exp;
      {dv, rb, wb, pa, ra, dat} = VEC[i];
      wr(2'd0, {25'd0, 1'b1, dv});
      rd(2'd0, v); check("R2 cfg readback", {32'd0, v}, {32'd0, 25'd0, 1'b1, dv});
      if (rb) phy_val = dat; else wr(2'd2, {16'd0, dat});
      rcnt = 0;
      wr(2'd1, ctl_word(rb, wb, pa, ra, 1'b1, 1'b0));
      rd(2'd1, v);
      check("R7 ready low", {63'd0, v[7]}, 64'd0);
      check("R2 ctl fields", {32'd0, v}, {32'd0, ctl_word(rb, wb, pa, ra, 1'b0, 1'b0)});
      wait_ready(polls);
      check("R7 ready back", {63'd0, polls < 3000}, 64'd1);
      @(negedge clk);
      check("R3 mdc idle", {63'd0, mdc}, 64'd0);
      check("R4 edge count", 64'(rcnt), 64'd64);
      exp = {32'hFFFF_FFFF, 2'b01, (rb ? 2'b10 : 2'b01), pa, ra, 2'b10, dat};
      check(rb ? "R10 R5 read frame" : "R4 R6 write frame", obs, exp);
      check("R3 mdc period", 64'(t2 - t1), 64'(2 * (int'(dv) + 1)));
      check("R5 R6 oe before TA", {63'd0, oe45}, 64'd1);
      check(rb ? "R5 oe released at TA" : "R6 oe held at TA", {63'd0, oe46}, {63'd0, !rb});
      if (rb) exp_rd = dat;
      rd(2'd3, v); check(rb ? "R5 read data" : "R6 rdata unchanged", {32'd0, v}, {48'd0, exp_rd});
    end

    // R9 writes during a frame are ignored
    wr(2'd0, 32'h0000_0042);
    wr(2'd2, 32'h0000_5A5A);
    rcnt = 0;
    wr(2'd1, ctl_word(1'b0, 1'b1, 5'h05, 5'h06, 1'b1, 1'b0));
    repeat (10) @(negedge clk);
    wr(2'd1, ctl_word(1'b1, 1'b0, 5'h1B, 5'h1C, 1'b1, 1'b0));
    wr(2'd0, 32'h0000_0007);
    wait_ready(polls);
    @(negedge clk);
    check("R9 frame intact", obs, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h06, 2'b10, 16'h5A5A});
    check("R9 single frame", 64'(rcnt), 64'd64);
    rd(2'd1, v); check("R9 ctl unchanged", {32'd0, v}, {32'd0, ctl_word(1'b0, 1'b1, 5'h05, 5'h06, 1'b0, 1'b1)});
    rd(2'd0, v); check("R9 cfg unchanged", {32'd0, v}, 64'h42);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule